// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block produces the address stream for a multi-register load or store. A single start pulse hands it a base address, a 16-bit mask of selected registers, a two-bit addressing mode and a writeback enable. It then issues one word access for each selected register over a request/ready handshake. Each access carries the register index, the word address and a flag that marks the final access. It does not move data, and it holds no register file.

Registers are always visited from the lowest index to the highest. The mode only decides where the address window begins and in which direction the base moves. In decrementing modes the lowest register still lands at the lowest address. A stack push is the decrement-before mode applied to the stack pointer, and a pop is the increment-after mode applied to the same pointer. When the sequence ends, the block pulses a done strobe. If writeback was requested, it also publishes the updated base.

Top module: `blkx_seq`

## Requirements
- R1: After reset, busy_o, req_o, done_o and base_wr_o are low and base_o is zero.
- R2: Each register whose mask bit is set is issued exactly once, in strictly ascending index order, and no unselected index is ever issued.
- R3: The mode encoding sets the first address, where N is the number of set mask bits: 2'b00 (up, step after) starts at base; 2'b01 (up, step before) starts at base+4; 2'b10 (down, step after) starts at base-4N+4; 2'b11 (down, step before) starts at base-4N. Each following access is 4 above the previous one.
- R4: last_o is high on the final access of a sequence and low on every other access.
- R5: While req_o is high and ready_i is low, req_o, reg_idx_o, addr_o and last_o hold their values.
- R6: done_o rises in the cycle after the final access is accepted and stays high for exactly one cycle.
- R7: The final base is base+4N for modes 2'b00 and 2'b01, and base-4N for modes 2'b10 and 2'b11. It appears on base_o, together with base_wr_o high during the done cycle, only when writeback was enabled. Otherwise base_o keeps its earlier value and base_wr_o stays low.
- R8: An all-zero mask raises done_o in the cycle after start with no request at all. With writeback enabled, base_o becomes the unchanged base.
- R9: Inputs are captured at an accepted start. A start raised while busy_o is high is ignored, and changes to the inputs after capture have no effect on the running sequence.
- R10: A push (mode 2'b11 with writeback) followed by a pop (mode 2'b00 with writeback) with the same mask, fed from the pushed base, returns base_o to the original base and covers the same address window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| base_i | input | ADDR_W | Base address |
| mask_i | input | NREG | Register-select mask |
| mode_i | input | 2 | Addressing mode (bit 1 = down, bit 0 = step before) |
| wb_en_i | input | 1 | Writeback enable |
| busy_o | output | 1 | Sequence in progress |
| req_o | output | 1 | Access request valid |
| ready_i | input | 1 | Memory accepts the current access |
| reg_idx_o | output | IDX_W | Register index of the current access |
| addr_o | output | ADDR_W | Word address of the current access |
| last_o | output | 1 | Current access is the final one |
| done_o | output | 1 | One-cycle completion strobe |
| base_wr_o | output | 1 | Updated base is valid on base_o (done cycle, writeback only) |
| base_o | output | ADDR_W | Updated base value |

## Verification
The bench sweeps every mode against single-bit masks at both ends, the full mask, an empty mask and sparse patterns. Each combination runs with writeback on and off, and with ready held high or stalled. A design that walked the mask from the top in decrement modes would issue indices in the wrong order. One that placed the window off by one word in a "before" or "after" mode would produce every address 4 bytes out. The empty mask exposes a design that issues a stray access or never finishes. Stalls expose a design that advances while ready is low. A start poked in mid-sequence, followed by a push/pop pair, shows whether inputs are re-captured while busy and whether the two stack modes are each other's inverse.

// File: rtl/blkx_pkg.sv
package blkx_pkg;
   typedef enum logic [1:0] {
      AM_UP_POST = 2'b00,
      AM_UP_PRE  = 2'b01,
      AM_DN_POST = 2'b10,
      AM_DN_PRE  = 2'b11
   } amode_e;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'b00,
      SQ_XFER = 2'b01,
      SQ_FIN  = 2'b10
   } sq_state_e;
endpackage

// File: rtl/blkx_popcnt.sv
module blkx_popcnt #(
   parameter int NREG  = 16,
   parameter int CNT_W = $clog2(NREG + 1)
) (
   input  logic [NREG-1:0]  vec_i,
   output logic [CNT_W-1:0] cnt_o
);
   logic [CNT_W-1:0] part [NREG+1];

   assign part[0] = '0;
   for (genvar g = 0; g < NREG; g++) begin : g_sum
      assign part[g+1] = part[g] + CNT_W'(vec_i[g]);
   end
   assign cnt_o = part[NREG];
endmodule

// File: rtl/blkx_lowbit.sv
module blkx_lowbit #(
   parameter int NREG  = 16,
   parameter int IDX_W = $clog2(NREG)
) (
   input  logic [NREG-1:0]  vec_i,
   output logic [IDX_W-1:0] idx_o,
   output logic [NREG-1:0]  rest_o
);
   logic [NREG-1:0] iso;

   // isolate lowest set bit
   assign iso    = vec_i & (~vec_i + NREG'(1));
   assign rest_o = vec_i & ~iso;

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < NREG; i++) begin
         if (iso[i]) idx_o = idx_o | IDX_W'(i);
      end
   end
endmodule

// File: rtl/blkx_addr_gen.sv
module blkx_addr_gen import blkx_pkg::*; #(
   parameter int ADDR_W  = 32,
   parameter int CNT_W   = 5,
   parameter int STEP_SH = 2
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  amode_e            mode_i,
   output logic [ADDR_W-1:0] start_o,
   output logic [ADDR_W-1:0] final_o
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << STEP_SH;

   logic [ADDR_W-1:0] span;
   assign span = ADDR_W'(cnt_i) << STEP_SH;

   always_comb begin
      unique case (mode_i)
         AM_UP_POST: start_o = base_i;
         AM_UP_PRE:  start_o = base_i + STEP;
         AM_DN_POST: start_o = base_i - span + STEP;
         default:    start_o = base_i - span;
      endcase
      final_o = mode_i[1] ? (base_i - span) : (base_i + span);
   end
endmodule

// File: rtl/blkx_seq.sv
module blkx_seq import blkx_pkg::*; #(
   parameter int ADDR_W     = 32,
   parameter int NREG       = 16,
   parameter int WORD_BYTES = 4,
   parameter int IDX_W      = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [NREG-1:0]   mask_i,
   input  logic [1:0]        mode_i,
   input  logic              wb_en_i,
   output logic              busy_o,
   output logic              req_o,
   input  logic              ready_i,
   output logic [IDX_W-1:0]  reg_idx_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              last_o,
   output logic              done_o,
   output logic              base_wr_o,
   output logic [ADDR_W-1:0] base_o
);
   localparam int CNT_W   = $clog2(NREG + 1);
   localparam int STEP_SH = $clog2(WORD_BYTES);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << STEP_SH;

   if (NREG < 2) begin : g_chk_nreg
      $error("blkx_seq: NREG must be at least 2");
   end
   if ((1 << STEP_SH) != WORD_BYTES) begin : g_chk_word
      $error("blkx_seq: WORD_BYTES must be a power of two");
   end
   if (ADDR_W <= CNT_W + STEP_SH) begin : g_chk_addr
      $error("blkx_seq: ADDR_W too narrow for the transfer span");
   end

   sq_state_e         state_q;
   logic [NREG-1:0]   rem_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] fin_q;
   logic              wb_q;
   logic [ADDR_W-1:0] base_q;

   logic [CNT_W-1:0]  cnt;
   logic [ADDR_W-1:0] start_addr;
   logic [ADDR_W-1:0] fin_base;
   logic [NREG-1:0]   rem_next;
   logic [IDX_W-1:0]  low_idx;
   logic              accept;
   logic              fire;

   blkx_popcnt #(.NREG(NREG), .CNT_W(CNT_W)) i_popcnt (
      .vec_i (mask_i),
      .cnt_o (cnt)
   );

   blkx_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STEP_SH(STEP_SH)) i_addr_gen (
      .base_i  (base_i),
      .cnt_i   (cnt),
      .mode_i  (amode_e'(mode_i)),
      .start_o (start_addr),
      .final_o (fin_base)
   );

   blkx_lowbit #(.NREG(NREG), .IDX_W(IDX_W)) i_lowbit (
      .vec_i  (rem_q),
      .idx_o  (low_idx),
      .rest_o (rem_next)
   );

   assign accept = (state_q == SQ_IDLE) && start_i;
   assign fire   = (state_q == SQ_XFER) && ready_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         rem_q   <= '0;
         addr_q  <= '0;
         fin_q   <= '0;
         wb_q    <= 1'b0;
         base_q  <= '0;
      end else begin
         unique case (state_q)
            SQ_IDLE: if (accept) begin
               rem_q  <= mask_i;
               addr_q <= start_addr;
               fin_q  <= fin_base;
               wb_q   <= wb_en_i;
               if (mask_i == '0) begin
                  state_q <= SQ_FIN;
                  if (wb_en_i) base_q <= fin_base;
               end else begin
                  state_q <= SQ_XFER;
               end
            end
            SQ_XFER: if (fire) begin
               rem_q  <= rem_next;
               addr_q <= addr_q + STEP;
               if (rem_next == '0) begin
                  state_q <= SQ_FIN;
                  if (wb_q) base_q <= fin_q;
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign busy_o    = (state_q != SQ_IDLE);
   assign req_o     = (state_q == SQ_XFER);
   assign reg_idx_o = low_idx;
   assign addr_o    = addr_q;
   assign last_o    = req_o && (rem_next == '0);
   assign done_o    = (state_q == SQ_FIN);
   assign base_wr_o = done_o && wb_q;
   assign base_o    = base_q;

   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && !ready_i) |=> (req_o && $stable(addr_o) && $stable(reg_idx_o) && $stable(last_o)));

   a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && ready_i && last_o) |=> (done_o && !req_o));

   a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && ready_i && !last_o) |=> (req_o && addr_o == $past(addr_o) + STEP));

   a_r2_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && ready_i && !last_o) |=> (reg_idx_o > $past(reg_idx_o)));

   a_r7_base_only_on_wb: assert property (@(posedge clk) disable iff (!rst_n)
      (base_o != $past(base_o)) |-> base_wr_o);

   a_r8_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i && mask_i == '0) |=> (done_o && !req_o));

   a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && !ready_i && start_i) |=> req_o);
endmodule

// File: tb/test_blkx_seq.sv
module test_blkx_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] base_i = '0;
   logic [15:0] mask_i = '0;
   logic [1:0]  mode_i = '0;
   logic        wb_en_i = 1'b0;
   logic        ready_i = 1'b0;
   logic        busy_o, req_o, last_o, done_o, base_wr_o;
   logic [3:0]  reg_idx_o;
   logic [31:0] addr_o, base_o;

   int n_chk = 0;
   int n_bad = 0;
   logic [31:0] exp_base = '0;

   always #10 clk = ~clk;

   blkx_seq #(.ADDR_W(32), .NREG(16), .WORD_BYTES(4)) i_blkx_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
      .mask_i(mask_i), .mode_i(mode_i), .wb_en_i(wb_en_i), .busy_o(busy_o),
      .req_o(req_o), .ready_i(ready_i), .reg_idx_o(reg_idx_o), .addr_o(addr_o),
      .last_o(last_o), .done_o(done_o), .base_wr_o(base_wr_o), .base_o(base_o)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run_op(input logic [31:0] b, input logic [15:0] m, input logic [1:0] md,
                         input logic wb, input bit stall, input bit poke);
      int n = 0;
      int j = 0;
      int k = 0;
      int cyc = 0;
      bit fin_seen = 0;
      bit exp_done = 0;
      logic [31:0] st, fin;
      for (int i = 0; i < 16; i++) n += int'(m[i]);
      case (md)
         2'b00: st = b;
         2'b01: st = b + 32'd4;
         2'b10: st = b - 32'(4 * n) + 32'd4;
         default: st = b - 32'(4 * n);
      endcase
      fin = md[1] ? b - 32'(4 * n) : b + 32'(4 * n);
      @(negedge clk);
      start_i = 1'b1; base_i = b; mask_i = m; mode_i = md; wb_en_i = wb;
      @(negedge clk);
      start_i = 1'b0; base_i = ~b; mask_i = ~m; mode_i = ~md; wb_en_i = ~wb; // R9 scramble
      while (!fin_seen && cyc < 120) begin
         start_i = (poke && cyc == 1);
         if (exp_done) chk(done_o == 1'b1, "R6 done after last", 32'(done_o), 32'd1);
         if (done_o) begin
            chk(j == n, "R2 access count", 32'(j), 32'(n));
            chk(req_o == 1'b0, "R6 no req on done", 32'(req_o), 32'd0);
            chk(base_wr_o == wb, "R7 base_wr", 32'(base_wr_o), 32'(wb));
            if (wb) exp_base = fin;
            chk(base_o == exp_base, (n == 0) ? "R8 empty base" : "R7 final base", base_o, exp_base);
            fin_seen = 1;
            ready_i = 1'b0;
         end else if (req_o) begin
            int idx = -1;
            for (int i = 15; i >= k; i--) if (m[i]) idx = i;
            chk(int'(reg_idx_o) == idx, "R2 index order", 32'(reg_idx_o), 32'(idx));
            chk(addr_o == st + 32'(4 * j), "R3 address", addr_o, st + 32'(4 * j));
            chk(last_o == (j == n - 1), "R4 last flag", 32'(last_o), 32'(j == n - 1));
            ready_i = stall ? (cyc % 3 == 2) : 1'b1;   // R5 stalls
            if (ready_i) begin
               exp_done = (j == n - 1);
               j++;
               k = idx + 1;
            end
         end else begin
            chk(1'b0, "R8 idle while busy", 32'(busy_o), 32'd1);
            fin_seen = 1;
         end
         cyc++;
         @(negedge clk);
      end
      start_i = 1'b0;
      ready_i = 1'b0;
      chk(fin_seen, "R6 completion", 32'(fin_seen), 32'd1);
      chk(done_o == 1'b0 && busy_o == 1'b0, "R6 single done cycle", 32'(done_o), 32'd0);
      chk(base_o == exp_base, "R7 base held", base_o, exp_base);
   endtask

   initial begin
      fork
         begin
            #(20 * 150000);
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
         end
      join_none
   end

   initial begin
      logic [15:0] masks [6];
      logic [31:0] orig;
      masks = '{16'h0001, 16'h8000, 16'hFFFF, 16'h0000, 16'hA5C3, 16'h0110};
      #35;
      chk(busy_o == 0 && req_o == 0 && done_o == 0 && base_wr_o == 0, "R1 reset outputs",
          {28'd0, busy_o, req_o, done_o, base_wr_o}, 32'd0);
      chk(base_o == 32'd0, "R1 reset base", base_o, 32'd0);
      rst_n = 1'b1;
      for (int md = 0; md < 4; md++)
         for (int mi = 0; mi < 6; mi++)
            for (int wb = 0; wb < 2; wb++)
               for (int st = 0; st < 2; st++)
                  run_op(32'h0000_4000 + 32'(md * 256 + mi * 16), masks[mi], 2'(md),
                         1'(wb), bit'(st), (st == 1 && mi == 4));
      // R10 push then pop
      orig = 32'h2000_0100;
      run_op(orig, 16'h40F2, 2'b11, 1'b1, 1'b1, 1'b0);
      chk(base_o == orig - 32'd24, "R10 push base", base_o, orig - 32'd24);
      run_op(base_o, 16'h40F2, 2'b00, 1'b1, 1'b0, 1'b0);
      chk(base_o == orig, "R10 pop restores base", base_o, orig);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule